// File: doc/BRIEF.md
# Packed Halfword Saturating Arithmetic Unit

This block treats each 64-bit operand as four separate 16-bit lanes. It applies one of seven lane-wise operations to each pair of lanes: add or subtract clamped to the signed halfword range, add or subtract clamped to the unsigned halfword range, an unsigned average with a sticky low bit, and a scaled add that shifts the first lane left or right by 0 to 3 before it adds the second. A carry never crosses from one lane into the next. Every lane is clamped after its full intermediate result is formed, so a result that overflows is always pinned to the correct bound.

Operands enter on a valid/ready input stream and results leave on a valid/ready output stream. A single output register sits between them. An operand set is taken on any rising edge where `in_valid` and `in_ready` are both high. Its result appears on `out_data`, with `out_valid` high, from the next edge. `in_ready` is high while the output register is empty or while the consumer drains it in that same cycle. A held result therefore never blocks the stream for more than the cycle in which it leaves. While `out_valid` is high and `out_ready` is low, the result and `out_valid` hold, and no new input is taken.

Top module: `psat_unit`

## Requirements
- R1: Lanes occupy bits 15:0, 31:16, 47:32 and 63:48. Each lane result depends only on the same lane of both operands, and a carry or borrow never crosses into a neighbouring lane.
- R2: Op code 0 adds and op code 1 subtracts (first minus second). Both lanes are taken as signed, and the result is clamped to -32768..32767.
- R3: Op code 2 adds and op code 3 subtracts. The first lane is taken as unsigned and the second as signed, and the result is clamped to 0..65535.
- R4: Op code 4 forms the unsigned 17-bit sum of both lanes and returns it shifted right by one, with the discarded bit ORed into bit 0.
- R5: Op code 5 shifts the signed first lane left by `in_sh` (0..3) and adds the signed second lane. The exact sum is then clamped to the signed range.
- R6: Op code 6 shifts the signed first lane right arithmetically by `in_sh` and adds the signed second lane. The sum is then clamped to the signed range.
- R7: Op code 7 yields an all-zero result.
- R8: An operand set taken on an edge yields its result on `out_data`, with `out_valid` high, after that same edge. When `out_ready` is held high, one operand set can be taken on every edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low.
- R10: During reset and right after it, `out_valid` is low and `in_ready` is high.
- R11: `in_sh` has no effect on op codes 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| in_a | input | 64 | First operand, four 16-bit lanes |
| in_b | input | 64 | Second operand, four 16-bit lanes |
| in_op | input | 3 | Operation code (0..7) |
| in_sh | input | 2 | Shift amount for op codes 5 and 6 |
| out_valid | output | 1 | Result held on out_data |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Lane-wise result |

## Verification
The two functions that can fall in the same cycle are draining the held result and capturing a new operand set into that same register. The bench provokes this in two ways. First, it presents operand sets on consecutive edges with `out_ready` high. Second, it releases `out_ready` while a second operand set is already waiting behind a stalled result. It judges the outcome by checking, one cycle after each edge, that every result appears exactly once, in order, and carries the value computed for its own operands.

// File: rtl/psat_pkg.sv
package psat_pkg;
  localparam int LANE_W_DEF = 16;
  localparam int SH_W_DEF   = 2;

  typedef enum logic [2:0] {
    OP_ADD_SS = 3'd0,
    OP_SUB_SS = 3'd1,
    OP_ADD_US = 3'd2,
    OP_SUB_US = 3'd3,
    OP_AVG    = 3'd4,
    OP_SHL_AD = 3'd5,
    OP_SHR_AD = 3'd6,
    OP_NONE   = 3'd7
  } psat_op_e;
endpackage

// File: rtl/psat_clamp.sv
module psat_clamp #(
  parameter int W  = 16,
  parameter int IW = 21
) (
  input  logic signed [IW-1:0] sum_i,
  input  logic                 uns_i,
  output logic [W-1:0]         res_o
);
  localparam logic signed [IW-1:0] S_MAX = IW'((1 << (W-1)) - 1);
  localparam logic signed [IW-1:0] S_MIN = ~S_MAX;
  localparam logic signed [IW-1:0] U_MAX = IW'((1 << W) - 1);

  always_comb begin
    res_o = sum_i[W-1:0];
    if (uns_i) begin
      if (sum_i < 0)          res_o = '0;
      else if (sum_i > U_MAX) res_o = '1;
    end else begin
      if (sum_i > S_MAX)      res_o = {1'b0, {(W-1){1'b1}}};
      else if (sum_i < S_MIN) res_o = {1'b1, {(W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/psat_lane.sv
module psat_lane
  import psat_pkg::*;
#(
  parameter int W    = 16,
  parameter int SH_W = 2
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  psat_op_e        op_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [W-1:0]    res_o
);
  // headroom: largest left shift plus one carry bit plus one spare
  localparam int IW = W + (1 << SH_W) + 1;

  logic signed [IW-1:0] a_s, b_s, a_z, b_z, sum;
  logic                 uns;
  logic [W-1:0]         clamped, avg;

  assign a_s = {{(IW-W){a_i[W-1]}}, a_i};
  assign b_s = {{(IW-W){b_i[W-1]}}, b_i};
  assign a_z = {{(IW-W){1'b0}}, a_i};
  assign b_z = {{(IW-W){1'b0}}, b_i};

  always_comb begin
    uns = 1'b0;
    unique case (op_i)
      OP_ADD_SS: sum = a_s + b_s;
      OP_SUB_SS: sum = a_s - b_s;
      OP_ADD_US: begin sum = a_z + b_s; uns = 1'b1; end
      OP_SUB_US: begin sum = a_z - b_s; uns = 1'b1; end
      OP_AVG:    sum = a_z + b_z;
      OP_SHL_AD: sum = (a_s <<< sh_i) + b_s;
      OP_SHR_AD: sum = (a_s >>> sh_i) + b_s;
      default:   sum = '0;
    endcase
  end

  // sticky average: keep bits W..1, fold the dropped bit into bit 0
  assign avg = {sum[W:2], sum[1] | sum[0]};

  psat_clamp #(.W(W), .IW(IW)) u_clamp (
    .sum_i (sum),
    .uns_i (uns),
    .res_o (clamped)
  );

  always_comb begin
    unique case (op_i)
      OP_AVG:  res_o = avg;
      OP_NONE: res_o = '0;
      default: res_o = clamped;
    endcase
  end
endmodule

// File: rtl/psat_unit.sv
module psat_unit
  import psat_pkg::*;
#(
  parameter  int LANES  = 4,
  parameter  int LANE_W = LANE_W_DEF,
  parameter  int SH_W   = SH_W_DEF,
  localparam int DW     = LANES * LANE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  input  logic [2:0]      in_op,
  input  logic [SH_W-1:0] in_sh,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data
);
  logic [DW-1:0] lane_res;
  logic          accept;
  psat_op_e      op;

  assign op       = psat_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    psat_lane #(.W(LANE_W), .SH_W(SH_W)) u_lane (
      .a_i   (in_a[g*LANE_W +: LANE_W]),
      .b_i   (in_b[g*LANE_W +: LANE_W]),
      .op_i  (op),
      .sh_i  (in_sh),
      .res_o (lane_res[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= lane_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == 3'd7) |=> (out_data == '0));

  assert_avg_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == 3'd4 && in_a == in_b) |=> (out_data == $past(in_a)));

  assert_add_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_op == 3'd0 && in_b == '0) |=> (out_data == $past(in_a)));
endmodule

// File: tb/psat_unit_tb.sv
module psat_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // fields: op[196:194] sh[193:192] a[191:128] b[127:64] expected[63:0]
  localparam logic [196:0] VEC [NV] = '{
    {3'd0, 2'd0, 64'h7FFF_8000_0001_1234, 64'h0001_FFFF_0001_0010, 64'h7FFF_8000_0002_1244},
    {3'd1, 2'd0, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0007_8000, 64'h8000_7FFF_FFFE_7FFF},
    {3'd2, 2'd0, 64'hFFFF_0005_8000_0010, 64'h0001_FFF0_0100_FFFF, 64'hFFFF_0000_8100_000F},
    {3'd3, 2'd0, 64'h0003_FFFF_1000_0000, 64'h0005_8000_0001_FFFF, 64'h0000_FFFF_0FFF_0001},
    {3'd4, 2'd0, 64'hFFFF_0003_0004_8000, 64'hFFFF_0000_0006_8001, 64'hFFFF_0001_0005_8001},
    {3'd5, 2'd3, 64'h1000_FFFF_0100_F000, 64'h0000_0001_0005_8000, 64'h7FFF_FFF9_0805_8000},
    {3'd5, 2'd0, 64'h7FFF_0001_0002_0003, 64'h0001_0001_0001_0001, 64'h7FFF_0002_0003_0004},
    {3'd6, 2'd2, 64'h8000_0007_FFFF_7FFF, 64'h0000_0001_0000_7FFF, 64'hE000_0002_FFFF_7FFF},
    {3'd6, 2'd3, 64'h0010_FFF0_0000_0000, 64'h8000_0000_0000_0000, 64'h8002_FFFE_0000_0000},
    {3'd7, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_sh = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psat_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .in_sh(in_sh),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4:       return "R4";
      3'd5:       return "R5";
      3'd6:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] sh,
                       input logic [63:0] a, input logic [63:0] b);
    in_op = op; in_sh = sh; in_a = a; in_b = b; in_valid = 1'b1;
  endtask

  // one operand set, result checked one edge later
  task automatic send(input string tag, input logic [2:0] op, input logic [1:0] sh,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp);
    @(negedge clk);
    drive(op, sh, a, b);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check(tag, out_data, exp);
  endtask

  initial begin
    // R10: reset state, out_ready low so in_ready depends on an empty register
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", 64'(out_valid), 64'd0);
    check("R10 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 out_valid after reset", 64'(out_valid), 64'd0);
    check("R10 in_ready after reset", 64'(in_ready), 64'd1);
    out_ready = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(req_of(VEC[i][196:194]), VEC[i][196:194], VEC[i][193:192],
           VEC[i][191:128], VEC[i][127:64], VEC[i][63:0]);
    end

    // R1: lane 0 saturates, lane 1 receives no carry
    send("R1", 3'd2, 2'd0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001,
         64'h0000_0000_7FFF_FFFF);
    send("R1 borrow", 3'd1, 2'd0, 64'h0001_0000_0000_0000, 64'h0000_0001_0000_0000,
         64'h0001_FFFF_0000_0000);

    // R11: shift amount ignored for non-shift ops
    send("R11 add", 3'd0, 2'd3, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001,
         64'h0002_0002_0002_0002);
    send("R11 avg", 3'd4, 2'd2, 64'h0002_0002_0002_0002, 64'h0004_0004_0004_0004,
         64'h0003_0003_0003_0003);

    // R8: back-to-back, drain and capture in the same edge
    @(negedge clk);
    drive(3'd0, 2'd0, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001);
    @(negedge clk);
    check("R8 stream first", out_data, 64'h0002_0002_0002_0002);
    drive(3'd1, 2'd0, 64'h0005_0005_0005_0005, 64'h0001_0001_0001_0001);
    @(negedge clk);
    check("R8 stream second", out_data, 64'h0004_0004_0004_0004);
    check("R8 stream valid", 64'(out_valid), 64'd1);
    drive(3'd4, 2'd0, 64'h0006_0006_0006_0006, 64'h0006_0006_0006_0006);
    @(negedge clk);
    check("R8 stream third", out_data, 64'h0006_0006_0006_0006);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 drained", 64'(out_valid), 64'd0);

    // R9: stall with a second set waiting, then release
    out_ready = 1'b0;
    drive(3'd0, 2'd0, 64'h0010_0010_0010_0010, 64'h0001_0001_0001_0001);
    @(negedge clk);
    drive(3'd0, 2'd0, 64'h0020_0020_0020_0020, 64'h0002_0002_0002_0002);
    check("R9 in_ready low", 64'(in_ready), 64'd0);
    @(negedge clk);
    check("R9 data held", out_data, 64'h0011_0011_0011_0011);
    check("R9 valid held", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 waiting set taken", out_data, 64'h0022_0022_0022_0022);
    check("R9 valid after release", 64'(out_valid), 64'd1);
    @(negedge clk);
    check("R9 empty after drain", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule